// File: doc/BRIEF.md
# Display Bridge Configuration Register Target

This block is the serial configuration port of a display bridge. It listens on a two-wire I2C bus as a target device. It holds a bank of 256 sixteen-bit configuration words, indexed by one byte. The decoded control bits are driven onto parallel output ports for the rest of the bridge. The bus pins arrive as plain levels. The block drives a single pull-down enable for the data line, and the pad logic outside the block turns that enable into an open-drain output.

A host writes a word in one transaction: the target address with the write bit, then an index byte, then the low data byte, then the high data byte. The word takes effect only when the high byte has been acknowledged. To read, the host loads the index with a write that carries only the index byte. It then issues a start (repeated or fresh) with the read bit and clocks out the low byte first, then the high byte. While the host keeps acknowledging, the read continues through the following indices. Word 0x00 reports the strapped bus address. Bit 15 of word 0x30 reports the panel power state from an input pin.

The controller is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WIDX` / `ST_WIDX_ACK`: receiving and acknowledging the index byte.
- `ST_WLO` / `ST_WLO_ACK`: receiving and acknowledging the low data byte.
- `ST_WHI` / `ST_WHI_ACK`: receiving and acknowledging the high data byte.
- `ST_RD`: shifting out a data byte.
- `ST_RD_ACK`: sampling the host's acknowledge.
- `ST_IGNORE`: released from the bus until the next start.

The transitions are:
- A start takes every state to `ST_ADDR`.
- A stop takes every state to `ST_IDLE`.
- At the eighth SCL fall, `ST_ADDR` moves to `ST_ADDR_ACK` when the address matches and to `ST_IGNORE` when it does not.
- At the eighth SCL fall, each write-data state moves to its ACK state.
- At the SCL fall that ends the acknowledge, each ACK state moves on:
  - `ST_ADDR_ACK` goes to `ST_RD` or `ST_WIDX`, depending on the R/W bit.
  - `ST_WIDX_ACK` goes to `ST_WLO`.
  - `ST_WLO_ACK` goes to `ST_WHI`.
  - `ST_WHI_ACK` commits the word and goes to `ST_IGNORE`.
- `ST_RD` moves to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` returns to `ST_RD` on a host ACK and goes to `ST_IGNORE` on a host NACK.

Top module: `i2c_bridge_regs`

## Requirements
- R1: An address byte whose upper seven bits differ from `own_addr_i` is not acknowledged. The target then drives nothing and changes no state until the next start. A matching address byte is acknowledged (SDA held low in the ninth clock).
- R2: A write transaction is the address byte with R/W = 0, then the index byte, then the low data byte, then the high data byte. Every byte is acknowledged. The word is stored only after the high byte has been acknowledged.
- R3: A stop or start that arrives after only the low data byte leaves the register unchanged.
- R4: A read (address byte with R/W = 1) returns the word at the most recently loaded index, low byte first, MSB first within each byte. The index is loaded by a write that carries only the index byte.
- R5: While the host acknowledges, a read continues. After the high byte it moves to the low byte of the next index, wrapping from 0xFF to 0x00.
- R6: Word 0x00 reads `{9'b0, own_addr_i}` at all times. Host writes to it have no effect.
- R7: Word 0x01 drives the outputs as follows: bit0 to `out_clk_en_o`, bit1 to `bypass_en_o`, bit2 to `lcd_en_o`, bit3 to `fit_en_o`, bit4 to `dither_en_o`. The outputs follow one clock after the commit.
- R8: Word 0x30 bit 15 reads `panel_on_i`, and writes to that bit are ignored. Bits 14:0 of word 0x30 store what was written.
- R9: After reset, every stored word and the index are zero, and all control outputs are low.
- R10: `sda_pull_o` changes only while SCL is low. It is asserted only in the acknowledge states and for zero bits being sent.
- R11: A start (SDA falling while SCL is high) restarts address reception from any state. A stop (SDA rising while SCL is high) returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the bus is oversampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 7 | Strapped 7-bit bus address |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| sda_pull_o | output | 1 | High to pull the data line low |
| panel_on_i | input | 1 | Panel power status, reported in word 0x30 bit 15 |
| out_clk_en_o | output | 1 | Word 0x01 bit 0: output clock enable |
| bypass_en_o | output | 1 | Word 0x01 bit 1: repeater/bypass enable |
| lcd_en_o | output | 1 | Word 0x01 bit 2: LCD enable |
| fit_en_o | output | 1 | Word 0x01 bit 3: panel fit enable |
| dither_en_o | output | 1 | Word 0x01 bit 4: dither enable |

## Verification
The bench builds the block with its defaults: a two-stage input synchronizer and the full 256-word bank. The full bank is needed to reach the wrap from index 0xFF and the fixed words 0x00, 0x01 and 0x30. The bus is driven with a ten-clock half period. The three-cycle synchronizer and edge-detect delay therefore fall well inside the SCL low time, which makes the release of the data line after an acknowledge observable at the pin. The strap is also changed during the run, so the block is seen answering on a new address and refusing the old one.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 2 * BYTE_W;
    localparam int unsigned BADDR_W = 7;
    localparam int unsigned CTRL_W  = 5;

    // Fixed word indices whose behaviour the bridge depends on
    localparam logic [BYTE_W-1:0] IDX_ID   = 8'h00;
    localparam logic [BYTE_W-1:0] IDX_CTRL = 8'h01;
    localparam logic [BYTE_W-1:0] IDX_PWR  = 8'h30;
    localparam int unsigned       PWR_BIT  = 15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WIDX,
        ST_WIDX_ACK,
        ST_WLO,
        ST_WLO_ACK,
        ST_WHI,
        ST_WHI_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned CUR = STAGES - 1;
    localparam int unsigned PRV = STAGES;

    // Bits [CUR:0] synchronise, bit PRV keeps the previous settled level
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_rise_o = scl_pipe[CUR] & ~scl_pipe[PRV];
        scl_fall_o = ~scl_pipe[CUR] & scl_pipe[PRV];
        sda_o      = sda_pipe[CUR];
        start_o    = scl_pipe[CUR] & scl_pipe[PRV] & sda_pipe[PRV] & ~sda_pipe[CUR];
        stop_o     = scl_pipe[CUR] & scl_pipe[PRV] & ~sda_pipe[PRV] & sda_pipe[CUR];
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_bridge_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [BADDR_W-1:0] own_addr_i,
    input  logic [WORD_W-1:0]  rd_word_i,
    output logic [BYTE_W-1:0]  rd_index_o,
    output logic [BYTE_W-1:0]  wr_index_o,
    output logic [WORD_W-1:0]  wr_data_o,
    output logic               wr_commit_o,
    output logic               sda_pull_o,
    output tgt_state_e         state_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    tgt_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  bits_q;
    logic [BYTE_W-1:0] index_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [BYTE_W-1:0] tx_q;
    logic              rd_hi_q;
    logic              host_nack_q;
    logic              commit_q;

    logic byte_done;
    logic rx_state;
    logic bus_evt;

    assign byte_done = scl_fall_i && (bits_q == CNT_FULL);
    assign bus_evt   = start_i || stop_i;
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_WIDX) ||
                       (state_q == ST_WLO)  || (state_q == ST_WHI);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR: if (byte_done)
                    state_d = (shift_q[BYTE_W-1:1] == own_addr_i) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall_i)
                    state_d = shift_q[0] ? ST_RD : ST_WIDX;
                ST_WIDX:     if (byte_done)  state_d = ST_WIDX_ACK;
                ST_WIDX_ACK: if (scl_fall_i) state_d = ST_WLO;
                ST_WLO:      if (byte_done)  state_d = ST_WLO_ACK;
                ST_WLO_ACK:  if (scl_fall_i) state_d = ST_WHI;
                ST_WHI:      if (byte_done)  state_d = ST_WHI_ACK;
                ST_WHI_ACK:  if (scl_fall_i) state_d = ST_IGNORE;
                ST_RD:       if (byte_done)  state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall_i) state_d = host_nack_q ? ST_IGNORE : ST_RD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register and byte datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            shift_q     <= '0;
            bits_q      <= '0;
            index_q     <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            tx_q        <= '0;
            rd_hi_q     <= 1'b0;
            host_nack_q <= 1'b0;
            commit_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            commit_q <= 1'b0;
            if (bus_evt) begin
                bits_q <= '0;
            end else if (rx_state) begin
                if (scl_rise_i) begin
                    shift_q <= {shift_q[BYTE_W-2:0], sda_i};
                    bits_q  <= bits_q + 1'b1;
                end else if (byte_done) begin
                    bits_q <= '0;
                    case (state_q)
                        ST_WIDX: index_q <= shift_q;
                        ST_WLO:  lo_q    <= shift_q;
                        ST_WHI:  hi_q    <= shift_q;
                        default: ;
                    endcase
                end
            end else begin
                case (state_q)
                    ST_ADDR_ACK: if (scl_fall_i && shift_q[0]) begin
                        tx_q    <= rd_word_i[BYTE_W-1:0];
                        rd_hi_q <= 1'b0;
                        bits_q  <= '0;
                    end
                    ST_WHI_ACK: if (scl_fall_i) commit_q <= 1'b1;
                    ST_RD: begin
                        if (scl_rise_i) begin
                            bits_q <= bits_q + 1'b1;
                        end else if (byte_done) begin
                            bits_q <= '0;
                        end else if (scl_fall_i) begin
                            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i) begin
                            host_nack_q <= sda_i;
                        end else if (scl_fall_i && !host_nack_q) begin
                            if (rd_hi_q) begin
                                index_q <= index_q + 1'b1;
                                tx_q    <= rd_word_i[BYTE_W-1:0];
                            end else begin
                                tx_q    <= rd_word_i[WORD_W-1:BYTE_W];
                            end
                            rd_hi_q <= ~rd_hi_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WIDX_ACK, ST_WLO_ACK, ST_WHI_ACK: sda_pull_o = 1'b1;
            ST_RD:   sda_pull_o = ~tx_q[BYTE_W-1];
            default: sda_pull_o = 1'b0;
        endcase
        rd_index_o  = (state_q == ST_RD_ACK && rd_hi_q) ? index_q + 1'b1 : index_q;
        wr_index_o  = index_q;
        wr_data_o   = {hi_q, lo_q};
        wr_commit_o = commit_q;
        state_o     = state_q;
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_bridge_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [BYTE_W-1:0]  wr_index_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic [BYTE_W-1:0]  rd_index_i,
    input  logic [BADDR_W-1:0] own_addr_i,
    input  logic               panel_on_i,
    output logic [WORD_W-1:0]  rd_data_o,
    output logic [CTRL_W-1:0]  ctrl_o
);
    localparam int unsigned NUM_WORDS = 1 << BYTE_W;
    localparam logic [WORD_W-1:0] PWR_MASK = ~(WORD_W'(1) << PWR_BIT);

    logic [WORD_W-1:0] words_q [NUM_WORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (wr_en_i && wr_index_i != IDX_ID) begin
            if (wr_index_i == IDX_PWR) begin
                words_q[wr_index_i] <= wr_data_i & PWR_MASK;
            end else begin
                words_q[wr_index_i] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = words_q[rd_index_i];
        if (rd_index_i == IDX_ID) begin
            rd_data_o = {{(WORD_W-BADDR_W){1'b0}}, own_addr_i};
        end else if (rd_index_i == IDX_PWR) begin
            rd_data_o[PWR_BIT] = panel_on_i;
        end
        ctrl_o = words_q[IDX_CTRL][CTRL_W-1:0];
    end

endmodule

// File: rtl/i2c_bridge_regs.sv
module i2c_bridge_regs
    import i2c_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [BADDR_W-1:0] own_addr_i,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic               panel_on_i,
    output logic               out_clk_en_o,
    output logic               bypass_en_o,
    output logic               lcd_en_o,
    output logic               fit_en_o,
    output logic               dither_en_o
);
    logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
    tgt_state_e        fsm_state;
    logic [BYTE_W-1:0] rd_index, wr_index;
    logic [WORD_W-1:0] rd_word, wr_data;
    logic              wr_commit;
    logic [CTRL_W-1:0] ctrl;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_tgt_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .sda_i       (sda_s),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .own_addr_i  (own_addr_i),
        .rd_word_i   (rd_word),
        .rd_index_o  (rd_index),
        .wr_index_o  (wr_index),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .sda_pull_o  (sda_pull_o),
        .state_o     (fsm_state)
    );

    i2c_reg_bank bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_commit),
        .wr_index_i (wr_index),
        .wr_data_i  (wr_data),
        .rd_index_i (rd_index),
        .own_addr_i (own_addr_i),
        .panel_on_i (panel_on_i),
        .rd_data_o  (rd_word),
        .ctrl_o     (ctrl)
    );

    assign out_clk_en_o = ctrl[0];
    assign bypass_en_o  = ctrl[1];
    assign lcd_en_o     = ctrl[2];
    assign fit_en_o     = ctrl[3];
    assign dither_en_o  = ctrl[4];

endmodule

// File: rtl/i2c_bridge_regs_chk.sv
module i2c_bridge_regs_chk
    import i2c_bridge_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_commit,
    input logic [BYTE_W-1:0] wr_index,
    input logic [WORD_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl,
    input tgt_state_e        fsm_state
);
    // R10: the data line is only moved while the clock is low
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

    // R1: a target that was not addressed stays off the bus
    assert_ignore_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_IGNORE) |-> !sda_pull_o);

    // R2: a commit is a single-cycle event
    assert_commit_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_commit |=> !wr_commit);

    // R7: control outputs follow a committed write of word 0x01
    assert_ctrl_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_commit && wr_index == IDX_CTRL) |=> (ctrl == $past(wr_data[CTRL_W-1:0])));

    // R11: stop returns to idle, start restarts address reception
    assert_stop_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det |=> (fsm_state == ST_IDLE));

    assert_start_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_det |=> (fsm_state == ST_ADDR));

endmodule

bind i2c_bridge_regs i2c_bridge_regs_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .wr_commit  (wr_commit),
    .wr_index   (wr_index),
    .wr_data    (wr_data),
    .ctrl       (ctrl),
    .fsm_state  (fsm_state)
);

// File: tb/i2c_bridge_regs_tb_top.sv
module i2c_bridge_regs_tb_top;

    localparam int H = 10;
    localparam logic [6:0] ADDR_A = 7'h3A;
    localparam logic [6:0] ADDR_B = 7'h21;

    // {index, written word, expected read-back} with panel_on_i low
    localparam logic [39:0] VEC [0:5] = '{
        40'h01_001F_001F,
        40'h10_ABCD_ABCD,
        40'h30_FFFF_7FFF,
        40'h00_1234_003A,
        40'hFF_5A5A_5A5A,
        40'h01_8006_8006
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] own_addr = ADDR_A;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic panel_on = 1'b0;
    logic sda_pull, clk_en, byp_en, lcd_en, fit_en, dith_en;
    wire  sda_bus = sda_m & ~sda_pull;

    int n_chk = 0, n_fail = 0, r10_viol = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_bridge_regs dut_i (
        .clk_i(clk), .rst_ni(rst_n), .own_addr_i(own_addr),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull),
        .panel_on_i(panel_on), .out_clk_en_o(clk_en), .bypass_en_o(byp_en),
        .lcd_en_o(lcd_en), .fit_en_o(fit_en), .dither_en_o(dith_en)
    );

    // R10 monitor: pull-down may only change while the bench holds SCL low
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull != prev_pull && scl_m) r10_viol++;
        prev_pull <= sda_pull;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
        ack = (sda_bus == 1'b0);
        tick(H/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
            b[i] = sda_bus;
            tick(H/2); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        tick(1); sda_m = 1'b1;
    endtask

    task automatic write_word(input logic [6:0] a, input logic [7:0] idx,
                              input logic [15:0] d, output int acks);
        logic k;
        acks = 0;
        bus_start();
        send_byte({a, 1'b0}, k); acks += int'(k);
        send_byte(idx, k);       acks += int'(k);
        send_byte(d[7:0], k);    acks += int'(k);
        send_byte(d[15:8], k);   acks += int'(k);
        bus_stop();
    endtask

    task automatic read_words(input logic [6:0] a, input logic [7:0] idx,
                              input int n, output logic [31:0] d, output logic addr_ack);
        logic k;
        logic [7:0] b;
        d = '0;
        bus_start();
        send_byte({a, 1'b0}, addr_ack);
        send_byte(idx, k);
        bus_start();
        send_byte({a, 1'b1}, k);
        for (int j = 0; j < 2 * n; j++) begin
            recv_byte(j != 2 * n - 1, b);
            d[8*j +: 8] = b;
        end
        bus_stop();
    endtask

    function automatic logic [15:0] ctrl_pins();
        return {11'b0, dith_en, fit_en, lcd_en, byp_en, clk_en};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic ak;
        int acks;
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // R9: reset state
        check("R9 ctrl pins", ctrl_pins(), 16'h0000);
        check("R10 idle pull", {15'b0, sda_pull}, 16'h0000);
        read_words(ADDR_A, 8'h01, 1, rd, ak);
        check("R9 word01", rd[15:0], 16'h0000);
        read_words(ADDR_A, 8'h55, 1, rd, ak);
        check("R9 word55", rd[15:0], 16'h0000);

        // Table walk: R2 write framing, R4 read-back, R6 id word, R8 status bit
        for (int k = 0; k < 6; k++) begin
            write_word(ADDR_A, VEC[k][39:32], VEC[k][31:16], acks);
            check("R2 write acks", 16'(acks), 16'd4);
            read_words(ADDR_A, VEC[k][39:32], 1, rd, ak);
            check("R4/R6/R8 readback", rd[15:0], VEC[k][15:0]);
        end

        // R7: word 0x01 = 0x8006 drives bypass and lcd only
        check("R7 ctrl pins 06", ctrl_pins(), 16'h0006);
        write_word(ADDR_A, 8'h01, 16'h0019, acks);
        tick(2);
        check("R7 ctrl pins 19", ctrl_pins(), 16'h0019);

        // R8: status bit from the pin
        panel_on = 1'b1;
        read_words(ADDR_A, 8'h30, 1, rd, ak);
        check("R8 panel on", rd[15:0], 16'hFFFF);
        panel_on = 1'b0;

        // R1: wrong address is refused and the following bytes ignored
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        check("R1 nack addr", {15'b0, ak}, 16'h0000);
        send_byte(8'h01, ak);
        check("R1 ignored idx", {15'b0, ak}, 16'h0000);
        send_byte(8'h00, ak);
        send_byte(8'h00, ak);
        bus_stop();
        check("R1 ctrl kept", ctrl_pins(), 16'h0019);

        // R3: stop after the low byte discards the write
        bus_start();
        send_byte({ADDR_A, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_byte(8'h00, ak);
        bus_stop();
        tick(2);
        check("R3 ctrl kept", ctrl_pins(), 16'h0019);
        read_words(ADDR_A, 8'h01, 1, rd, ak);
        check("R3 word kept", rd[15:0], 16'h0019);

        // R11: start in mid-write restarts the transaction
        bus_start();
        send_byte({ADDR_A, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_byte(8'h1E, ak);
        bus_start();
        send_byte({ADDR_A, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_byte(8'h07, ak);
        send_byte(8'h00, ak);
        bus_stop();
        tick(2);
        check("R11 restart write", ctrl_pins(), 16'h0007);

        // R5: continued read crosses to the next index and wraps
        write_word(ADDR_A, 8'h11, 16'h1357, acks);
        read_words(ADDR_A, 8'h10, 2, rd, ak);
        check("R5 first word", rd[15:0], 16'hABCD);
        check("R5 next word", rd[31:16], 16'h1357);
        write_word(ADDR_A, 8'h00, 16'hFFFF, acks);
        read_words(ADDR_A, 8'hFF, 2, rd, ak);
        check("R5 wrap hi", rd[15:0], 16'h5A5A);
        check("R5 wrap to id", rd[31:16], 16'h003A);

        // R4: index loaded alone, then a fresh read transaction
        bus_start();
        send_byte({ADDR_A, 1'b0}, ak);
        send_byte(8'h10, ak);
        bus_stop();
        bus_start();
        send_byte({ADDR_A, 1'b1}, ak);
        begin
            logic [7:0] lo, hi;
            recv_byte(1'b1, lo);
            recv_byte(1'b0, hi);
            bus_stop();
            check("R4 index-only read", {hi, lo}, 16'hABCD);
        end

        // R6: change of strap
        own_addr = ADDR_B;
        tick(2);
        read_words(ADDR_B, 8'h00, 1, rd, ak);
        check("R6 new strap", rd[15:0], 16'h0021);
        check("R1 new addr ack", {15'b0, ak}, 16'h0001);
        read_words(ADDR_A, 8'h00, 1, rd, ak);
        check("R1 old addr nack", {15'b0, ak}, 16'h0000);
        own_addr = ADDR_A;

        check("R10 pull only on low scl", 16'(r10_viol), 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule